// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading a two-level page table held in memory. A requester hands it a virtual address and an access kind (load, store or fetch). The walker splits the address into an outer index, an inner index and a page offset. It bounds the outer index against a table length value. It then reads one entry from the outer table and one from the inner table that entry selects. It returns the physical address built from the final frame number and the untouched offset, or a fault code.

The walker works on one translation at a time. The table base and length inputs are captured when a request is taken, so software may reload them while a walk is running. Memory reads go through a request port with a valid/ready handshake and a separate read-data return. Each walk ends with a one-cycle response pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and both mem_req_valid and rsp_valid are 0.
- R2: A request is taken only while the walker is idle. req_ready is 0 from the cycle after a request is taken until the response pulse has gone, and no memory request is raised while req_ready is 1.
- R3: The first read goes to ptbr + 4 * vaddr[31:22]. The second read goes to {outer_entry[31:12], vaddr[21:12], 2'b00}.
- R4: On success, rsp_fault is 0 and rsp_paddr is {inner_entry[31:12], vaddr[11:0]}, after exactly two memory reads.
- R5: If vaddr[31:22] >= ptlr, rsp_fault is 1 (length fault) and no memory read is made. With ptlr = 0 every address faults.
- R6: An outer entry with bit 0 (valid) clear gives rsp_fault 2 after exactly one read.
- R7: An inner entry with bit 0 clear gives rsp_fault 3 after two reads.
- R8: Inner entry bit 1 allows loads (req_acc 0), bit 2 allows stores (req_acc 1) and bit 3 allows fetches (req_acc 2). A missing permission, or req_acc 3, gives rsp_fault 4. The permission bits of the outer entry have no effect.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, the request stays raised and mem_req_addr stays unchanged.
- R10: rsp_valid lasts exactly one cycle, and rsp_paddr is 0 whenever rsp_fault is nonzero.
- R11: ptbr and ptlr are sampled when the request is taken. Changes to them during a walk do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| ptbr | input | 32 | Outer table base address |
| ptlr | input | 11 | Number of outer entries in use |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 3 | 0 ok, 1 length, 2 outer invalid, 3 inner invalid, 4 protection |

## Verification
The assertions assume that the memory returns read data only for a read it has accepted, and at most one return per accepted read. The read-count checks rely on this. The bench memory model keeps one read outstanding at a time. It answers each read only after a fixed latency counted from the handshake. In some tests it stalls mem_req_ready every other pair of cycles, so it never produces an unrequested return.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int VA_W = 2 * IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [VA_W-1:0]   ptbr,
  input  logic [IDX_W:0]    ptlr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault
);
  localparam int FRM_W = VA_W - OFF_W;
  localparam logic [2:0] F_NONE = 3'd0, F_LEN = 3'd1, F_OUT = 3'd2, F_IN = 3'd3, F_PROT = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_RESP} state_t;
  state_t state;

  logic [VA_W-1:0]  va_q, base_q, paddr_q;
  logic [1:0]       acc_q;
  logic [FRM_W-1:0] frame_q;
  logic [2:0]       fault_q;

  wire [IDX_W-1:0] in_outer = req_vaddr[VA_W-1 -: IDX_W];
  wire [IDX_W-1:0] q_outer  = va_q[VA_W-1 -: IDX_W];
  wire [IDX_W-1:0] q_inner  = va_q[OFF_W +: IDX_W];
  wire             len_bad  = {1'b0, in_outer} >= ptlr;
  wire             ent_ok   = mem_rsp_data[0];
  wire             perm_ok  = (acc_q == 2'd0 && mem_rsp_data[1]) ||
                              (acc_q == 2'd1 && mem_rsp_data[2]) ||
                              (acc_q == 2'd2 && mem_rsp_data[3]);

  logic unused_entry_bits;
  assign unused_entry_bits = ^mem_rsp_data[OFF_W-1:4];

  assign req_ready     = state == S_IDLE;
  assign mem_req_valid = state == S_RD1 || state == S_RD2;
  assign mem_req_addr  = (state == S_RD1)
                       ? base_q + VA_W'({q_outer, 2'b00})
                       : {frame_q, {OFF_W{1'b0}}} | VA_W'({q_inner, 2'b00});
  assign rsp_valid     = state == S_RESP;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      acc_q   <= '0;
      frame_q <= '0;
      paddr_q <= '0;
      fault_q <= F_NONE;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          acc_q   <= req_acc;
          base_q  <= ptbr;
          paddr_q <= '0;
          if (len_bad) begin
            fault_q <= F_LEN;
            state   <= S_RESP;
          end else begin
            fault_q <= F_NONE;
            state   <= S_RD1;
          end
        end
        S_RD1: if (mem_req_ready) state <= S_WT1;
        S_WT1: if (mem_rsp_valid) begin
          if (!ent_ok) begin
            fault_q <= F_OUT;
            state   <= S_RESP;
          end else begin
            frame_q <= mem_rsp_data[VA_W-1:OFF_W];
            state   <= S_RD2;
          end
        end
        S_RD2: if (mem_req_ready) state <= S_WT2;
        S_WT2: if (mem_rsp_valid) begin
          state <= S_RESP;
          if (!ent_ok)       fault_q <= F_IN;
          else if (!perm_ok) fault_q <= F_PROT;
          else               paddr_q <= {mem_rsp_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int VA_W = 2 * IDX_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [VA_W-1:0]   mem_req_addr,
  input logic              rsp_valid,
  input logic [VA_W-1:0]   rsp_paddr,
  input logic [2:0]        rsp_fault
);
  logic [1:0]       rd_cnt;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      off_q  <= '0;
    end else if (req_valid && req_ready) begin
      rd_cnt <= '0;
      off_q  <= req_vaddr[OFF_W-1:0];
    end else if (mem_req_valid && mem_req_ready) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_paddr == '0); // R10
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R2
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd0 |-> rsp_paddr[OFF_W-1:0] == off_q); // R4
  AST_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == 3'd0 || rsp_fault == 3'd3 || rsp_fault == 3'd4) |-> rd_cnt == 2'd2); // R4
  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd1 |-> rd_cnt == 2'd0); // R5
  AST_OUTER_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd2 |-> rd_cnt == 2'd1); // R6
endmodule

bind pt_walker pt_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_acc = 0;
  logic [31:0] ptbr = 32'h0001_0000;
  logic [10:0] ptlr = 11'd8;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  always #2 clk = ~clk;

  pt_walker dut (.*);

  logic [31:0] mem [int unsigned];
  logic        stall_mode = 0;
  int          lat = 0;
  logic [3:0]  cyc = 0;
  logic        pend = 0;
  int          cnt = 0;
  logic [31:0] pa = 0;
  int          rd_total = 0;
  logic [31:0] addr_prev = 0, addr_last = 0;

  assign mem_req_ready = !stall_mode || cyc[1];

  always @(posedge clk) begin
    cyc <= cyc + 4'd1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(pa) ? mem[pa] : 32'h0;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      pend <= 1'b1;
      cnt  <= lat;
      pa   <= mem_req_addr;
      rd_total  <= rd_total + 1;
      addr_prev <= addr_last;
      addr_last <= mem_req_addr;
    end
  end

  int checks = 0, failures = 0;
  logic [31:0] r_paddr;
  logic [2:0]  r_fault;
  int          r_reads;
  logic        r_busy;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit disturb);
    int start;
    int guard;
    @(negedge clk);
    start = rd_total;
    req_vaddr = va;
    req_acc   = acc;
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    r_busy = req_ready;
    if (disturb) begin
      ptbr = 32'h0;
      ptlr = 11'd0;
    end
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    r_paddr = rsp_paddr;
    r_fault = rsp_fault;
    r_reads = rd_total - start;
    @(negedge clk);
  endtask

  localparam logic [31:0] VA_A = 32'h00C1_5123; // outer 3, inner 0x15, off 0x123

  task automatic t_reset();
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_load_ok();
    walk(VA_A, 2'd0, 0);
    chk("R4 paddr", r_paddr, 32'hABCD_E123);
    chk("R4 fault", {29'd0, r_fault}, 32'd0);
    chk("R4 reads", r_reads, 32'd2);
    chk("R3 outer addr", addr_prev, 32'h0001_000C);
    chk("R3 inner addr", addr_last, 32'h0002_0054);
    chk("R2 busy after take", {31'd0, r_busy}, 32'd0);
  endtask

  task automatic t_perms();
    walk(VA_A, 2'd1, 0);
    chk("R8 store allowed", {29'd0, r_fault}, 32'd0);
    walk(VA_A, 2'd2, 0);
    chk("R8 fetch denied", {29'd0, r_fault}, 32'd4);
    chk("R10 paddr zero on fault", r_paddr, 32'd0);
    walk(VA_A, 2'd3, 0);
    chk("R8 reserved kind", {29'd0, r_fault}, 32'd4);
    walk(32'h00C1_6FFF, 2'd2, 0);
    chk("R8 exec-only fetch", r_paddr, 32'h1234_5FFF);
    chk("R8 exec-only fetch fault", {29'd0, r_fault}, 32'd0);
    walk(32'h00C1_6FFF, 2'd0, 0);
    chk("R8 exec-only load", {29'd0, r_fault}, 32'd4);
    walk(32'h00C1_6FFF, 2'd1, 0);
    chk("R8 exec-only store", {29'd0, r_fault}, 32'd4);
  endtask

  task automatic t_length();
    walk(32'h0200_0000, 2'd0, 0);
    chk("R5 idx==ptlr fault", {29'd0, r_fault}, 32'd1);
    chk("R5 no read", r_reads, 32'd0);
    ptlr = 11'd0;
    walk(32'h0000_0000, 2'd0, 0);
    chk("R5 ptlr zero", {29'd0, r_fault}, 32'd1);
    ptlr = 11'd8;
    walk(32'h01C0_0000, 2'd0, 0);
    chk("R6 outer invalid", {29'd0, r_fault}, 32'd2);
    chk("R6 one read", r_reads, 32'd1);
  endtask

  task automatic t_inner_invalid();
    walk(32'h00C1_7000, 2'd0, 0);
    chk("R7 inner invalid", {29'd0, r_fault}, 32'd3);
    chk("R7 two reads", r_reads, 32'd2);
  endtask

  task automatic t_stall();
    stall_mode = 1;
    lat = 3;
    walk(VA_A, 2'd0, 0);
    chk("R9 stalled paddr", r_paddr, 32'hABCD_E123);
    chk("R9 stalled reads", r_reads, 32'd2);
    stall_mode = 0;
    lat = 0;
  endtask

  task automatic t_snapshot();
    walk(VA_A, 2'd0, 1);
    chk("R11 base kept", r_paddr, 32'hABCD_E123);
    chk("R11 outer addr", addr_prev, 32'h0001_000C);
    ptbr = 32'h0001_0000;
    ptlr = 11'd8;
  endtask

  initial begin
    mem[32'h0001_000C] = 32'h0002_0001; // outer entry, no perm bits set
    mem[32'h0002_0054] = 32'hABCD_E007; // load+store
    mem[32'h0002_0058] = 32'h1234_5009; // fetch only
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_ok();
    t_perms();
    t_length();
    t_inner_invalid();
    t_stall();
    t_snapshot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule